// File: doc/BRIEF.md
# System Control Register Bank with Memory Maintenance Port

This block holds the configuration state that a small processor uses to govern its memory system: a control word with cache and translation enables, the base of the translation table, the access rights of sixteen domains, the status and address of the most recent memory fault, and a process identifier used for address relocation. The core reaches it through a simple access port. A register number, a secondary operand field (`acc_crm`), a three-bit opcode qualifier and write data are presented together with a write strobe. The selected register's value appears combinationally on the read data output.

Many control bits are fixed by the architecture and are forced to constant values instead of being stored. Writes to the two maintenance register numbers store nothing. They are decoded into one of ten cache or TLB commands. The chosen command is raised as a one-hot request toward the memory system and held there until that side returns a done pulse. A stall output tells the core to wait for the whole interval. The MMU can load the fault registers directly through a capture strobe, and that strobe wins over a software write in the same cycle.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the control register (number 1) reads 0x00004878. Registers 2, 3, 5, 6 and 13 read zero, register 0 reads the ID_VALUE parameter (default 0x5A010003), and `stall` and `mem_req` are zero.
- R2: In the control register, only bits 0, 2, 8, 9 and 12 store written data. Writing 0xFFFFFFFF reads back 0x00005B7D, and writing 0x00001001 reads back 0x00005879.
- R3: Control bits 3, 4, 5, 6, 11 and 14 always read 1. Every other bit that is not writable always reads 0, whatever value is written.
- R4: A write to register 2 updates bits 31:14 only. Bits 13:0 keep their previous value, which is zero from reset.
- R5: Register 3 stores all 32 bits as sixteen 2-bit domain fields, with domain X in bits 2X+1:2X.
- R6: Register 5 reads {24'b0, domain[3:0], status[3:0]}, so bits 31:8 (including 11:8) always read zero. Register 6 holds a full 32-bit fault address. Both registers can be written by software.
- R7: Register 13 stores bits 31:25 as the process ID. All other bits read zero.
- R8: A write to register 7 raises exactly one `mem_req` bit. The mapping is: bit0 flush all caches (crm 0111), bit1 flush I (0101), bit2 flush D (0110), bit3 clean all (1011), bit4 clean D (1010), bit5 clean and flush all (1111), bit6 clean and flush D (1110). These codes apply only with opcode2 000. Any other crm, or any nonzero opcode2, selects bit5.
- R9: A write to register 8 raises `mem_req` bit7 for flush all TLBs (crm 0111), bit8 for flush I TLB (0101) or bit9 for flush D TLB (0110). These codes apply only with opcode2 000. Any other combination selects bit7.
- R10: The request appears in the cycle after the write edge and stays unchanged until a `mem_done` pulse is sampled. It clears at that edge. `stall` is high exactly while a request is held.
- R11: `flt_capture` loads register 5 from `flt_status` and `flt_domain`, and register 6 from `flt_addr`, at the same edge. It overrides a software write to either register in that cycle.
- R12: Register writes are ignored while `stall` is high. A `mem_done` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_reg | input | 4 | Register number |
| acc_crm | input | 4 | Secondary operand field used by the maintenance decode |
| acc_op2 | input | 3 | Opcode qualifier |
| acc_wdata | input | 32 | Write data |
| acc_we | input | 1 | Write strobe |
| acc_rdata | output | 32 | Read data of the selected register |
| stall | output | 1 | Core must wait while a maintenance command is pending |
| mem_req | output | 10 | One-hot maintenance command request |
| mem_done | input | 1 | Completion pulse from the memory system |
| flt_capture | input | 1 | Fault capture strobe from the MMU |
| flt_status | input | 4 | Fault status code |
| flt_domain | input | 4 | Domain of the faulting access |
| flt_addr | input | 32 | Faulting address |

## Verification
A bad stored bit in the control, translation-base, domain or process-ID registers shows on `acc_rdata` as soon as that register is selected after the write edge. This includes a fixed bit that leaks stored data. A wrong decode or a lost handshake state shows one cycle after the maintenance write: the wrong `mem_req` bit is raised, a request drops before `mem_done`, or `stall` stays high after the done edge. A write accepted while stalled is exposed when the protected register is read back after the command completes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int N_CMD = 10;
   typedef logic [N_CMD-1:0] cmd_vec_t;

   // one-hot command positions, decoded by the memory system
   localparam int CMD_C_FLUSH_ALL = 0;
   localparam int CMD_C_FLUSH_I   = 1;
   localparam int CMD_C_FLUSH_D   = 2;
   localparam int CMD_C_CLEAN_ALL = 3;
   localparam int CMD_C_CLEAN_D   = 4;
   localparam int CMD_C_CF_ALL    = 5;
   localparam int CMD_C_CF_D      = 6;
   localparam int CMD_T_ALL       = 7;
   localparam int CMD_T_I         = 8;
   localparam int CMD_T_D         = 9;

   // register numbers
   localparam logic [3:0] RN_ID    = 4'd0;
   localparam logic [3:0] RN_CTRL  = 4'd1;
   localparam logic [3:0] RN_TTB   = 4'd2;
   localparam logic [3:0] RN_DOM   = 4'd3;
   localparam logic [3:0] RN_FSR   = 4'd5;
   localparam logic [3:0] RN_FAR   = 4'd6;
   localparam logic [3:0] RN_CACHE = 4'd7;
   localparam logic [3:0] RN_TLB   = 4'd8;
   localparam logic [3:0] RN_PID   = 4'd13;
endpackage

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg #(
   parameter int          DW       = 32,
   parameter logic [31:0] WR_MASK  = 32'h0000_1305,
   parameter logic [31:0] ONE_MASK = 32'h0000_4878
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   if ((WR_MASK & ONE_MASK) != 32'h0) begin : g_bad_mask
      $error("writable and forced-one masks overlap");
   end

   logic unused_wbits;
   assign unused_wbits = ^(wdata & ~WR_MASK[DW-1:0]);

   for (genvar i = 0; i < DW; i++) begin : g_bit
      if (WR_MASK[i]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  bit_q <= 1'b0;
            else if (we) bit_q <= wdata[i];
         end
         assign q[i] = bit_q;
      end else if (ONE_MASK[i]) begin : g_one
         assign q[i] = 1'b1;
      end else begin : g_zero
         assign q[i] = 1'b0;
      end
   end

   AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      ((q & ONE_MASK[DW-1:0]) == ONE_MASK[DW-1:0]) && ((q & ~(WR_MASK[DW-1:0] | ONE_MASK[DW-1:0])) == '0)); // R3
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R2
endmodule

// File: rtl/sysctl_maint_decode.sv
module sysctl_maint_decode
   import sysctl_pkg::*;
#(
   parameter int CRMW = 4,
   parameter int OP2W = 3
) (
   input  logic            is_cache,
   input  logic            is_tlb,
   input  logic [CRMW-1:0] crm,
   input  logic [OP2W-1:0] op2,
   output cmd_vec_t        cmd
);
   if (CRMW != 4) begin : g_bad_crm
      $error("crm field must be 4 bits");
   end

   always_comb begin
      cmd = '0;
      if (is_cache) begin
         if (op2 == '0) begin
            case (crm)
               4'b0111: cmd[CMD_C_FLUSH_ALL] = 1'b1;
               4'b0101: cmd[CMD_C_FLUSH_I]   = 1'b1;
               4'b0110: cmd[CMD_C_FLUSH_D]   = 1'b1;
               4'b1011: cmd[CMD_C_CLEAN_ALL] = 1'b1;
               4'b1010: cmd[CMD_C_CLEAN_D]   = 1'b1;
               4'b1110: cmd[CMD_C_CF_D]      = 1'b1;
               default: cmd[CMD_C_CF_ALL]    = 1'b1;
            endcase
         end else begin
            cmd[CMD_C_CF_ALL] = 1'b1;
         end
      end else if (is_tlb) begin
         if (op2 == '0) begin
            case (crm)
               4'b0101: cmd[CMD_T_I]   = 1'b1;
               4'b0110: cmd[CMD_T_D]   = 1'b1;
               default: cmd[CMD_T_ALL] = 1'b1;
            endcase
         end else begin
            cmd[CMD_T_ALL] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sysctl_cmd_port.sv
module sysctl_cmd_port
   import sysctl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  cmd_vec_t cmd_in,
   input  logic     mem_done,
   output cmd_vec_t mem_req,
   output logic     busy
);
   cmd_vec_t req_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               req_q <= '0;
      else if (req_q == '0) begin
         if (start)             req_q <= cmd_in;
      end else if (mem_done)    req_q <= '0;
   end

   assign mem_req = req_q;
   assign busy    = |req_q;

   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_req)); // R8
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_done) |=> $stable(mem_req)); // R10
   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_done) |=> !busy); // R10
   AST_REQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (mem_req == $past(cmd_in))); // R10
   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy); // R12
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int          DW        = 32,
   parameter int          REGW      = 4,
   parameter int          CRMW      = 4,
   parameter int          OP2W      = 3,
   parameter int          N_DOM     = 16,
   parameter int          TTB_LSB   = 14,
   parameter int          PID_W     = 7,
   parameter int          FST_W     = 4,
   parameter logic [31:0] ID_VALUE  = 32'h5A01_0003,
   parameter logic [31:0] CTRL_WR   = 32'h0000_1305,
   parameter logic [31:0] CTRL_ONES = 32'h0000_4878
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [REGW-1:0] acc_reg,
   input  logic [CRMW-1:0] acc_crm,
   input  logic [OP2W-1:0] acc_op2,
   input  logic [DW-1:0]   acc_wdata,
   input  logic            acc_we,
   output logic [DW-1:0]   acc_rdata,
   output logic            stall,
   output logic [9:0]      mem_req,
   input  logic            mem_done,
   input  logic            flt_capture,
   input  logic [FST_W-1:0] flt_status,
   input  logic [FST_W-1:0] flt_domain,
   input  logic [DW-1:0]   flt_addr
);
   localparam int DOM_W   = DW / N_DOM;
   localparam int TTB_W   = DW - TTB_LSB;
   localparam int FSR_W   = 2 * FST_W;
   localparam int PID_LSB = DW - PID_W;

   if (DW != 32)             begin : g_bad_dw  $error("data width must be 32"); end
   if (REGW != 4)            begin : g_bad_rw  $error("register number must be 4 bits"); end
   if (DOM_W * N_DOM != DW)  begin : g_bad_dom $error("domains must tile the word"); end
   if (TTB_LSB >= DW)        begin : g_bad_ttb $error("table base LSB out of range"); end
   if (PID_W > DW)           begin : g_bad_pid $error("process ID too wide"); end
   if (FSR_W > 8)            begin : g_bad_fsr $error("fault status must fit in 8 bits"); end

   logic     wr_ok;
   cmd_vec_t dec_cmd;
   cmd_vec_t req_vec;
   logic     busy;

   assign wr_ok = acc_we && !busy;

   function automatic logic hit(input logic [REGW-1:0] a, input logic [3:0] n);
      return a == REGW'(n);
   endfunction

   // control word with forced bits
   logic [DW-1:0] ctrl_q;
   sysctl_ctrl_reg #(.DW(DW), .WR_MASK(CTRL_WR), .ONE_MASK(CTRL_ONES)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok && hit(acc_reg, RN_CTRL)),
      .wdata (acc_wdata),
      .q     (ctrl_q)
   );

   // translation table base: upper field only
   logic [TTB_W-1:0] ttb_q;
   always_ff @(posedge clk) begin
      if (!rst_n) ttb_q <= '0;
      else if (wr_ok && hit(acc_reg, RN_TTB)) ttb_q <= acc_wdata[DW-1:TTB_LSB];
   end

   // domain access fields
   logic [DW-1:0] dom_word;
   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      logic [DOM_W-1:0] fld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) fld_q <= '0;
         else if (wr_ok && hit(acc_reg, RN_DOM)) fld_q <= acc_wdata[d*DOM_W +: DOM_W];
      end
      assign dom_word[d*DOM_W +: DOM_W] = fld_q;
   end

   // fault status / address, MMU capture has priority
   logic [FSR_W-1:0] fsr_q;
   logic [DW-1:0]    far_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsr_q <= '0;
         far_q <= '0;
      end else if (flt_capture) begin
         fsr_q <= {flt_domain, flt_status};
         far_q <= flt_addr;
      end else begin
         if (wr_ok && hit(acc_reg, RN_FSR)) fsr_q <= acc_wdata[FSR_W-1:0];
         if (wr_ok && hit(acc_reg, RN_FAR)) far_q <= acc_wdata;
      end
   end

   // process ID
   logic [PID_W-1:0] pid_q;
   always_ff @(posedge clk) begin
      if (!rst_n) pid_q <= '0;
      else if (wr_ok && hit(acc_reg, RN_PID)) pid_q <= acc_wdata[DW-1:PID_LSB];
   end

   // maintenance commands
   sysctl_maint_decode #(.CRMW(CRMW), .OP2W(OP2W)) u_dec (
      .is_cache (hit(acc_reg, RN_CACHE)),
      .is_tlb   (hit(acc_reg, RN_TLB)),
      .crm      (acc_crm),
      .op2      (acc_op2),
      .cmd      (dec_cmd)
   );

   sysctl_cmd_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (wr_ok && (hit(acc_reg, RN_CACHE) || hit(acc_reg, RN_TLB))),
      .cmd_in   (dec_cmd),
      .mem_done (mem_done),
      .mem_req  (req_vec),
      .busy     (busy)
   );

   assign mem_req = req_vec;
   assign stall   = busy;

   // read mux
   always_comb begin
      acc_rdata = '0;
      case (acc_reg)
         REGW'(RN_ID):   acc_rdata = ID_VALUE[DW-1:0];
         REGW'(RN_CTRL): acc_rdata = ctrl_q;
         REGW'(RN_TTB):  acc_rdata = {ttb_q, {TTB_LSB{1'b0}}};
         REGW'(RN_DOM):  acc_rdata = dom_word;
         REGW'(RN_FSR):  acc_rdata = {{(DW-FSR_W){1'b0}}, fsr_q};
         REGW'(RN_FAR):  acc_rdata = far_q;
         REGW'(RN_PID):  acc_rdata = {pid_q, {PID_LSB{1'b0}}};
         default:        acc_rdata = '0;
      endcase
   end

   AST_FLT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      flt_capture |=> (fsr_q == $past({flt_domain, flt_status})) && (far_q == $past(flt_addr))); // R11
   AST_FSR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hit(acc_reg, RN_FSR) |-> (acc_rdata[DW-1:8] == '0)); // R6
   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !flt_capture) |=> $stable(ttb_q) && $stable(dom_word) && $stable(pid_q) && $stable(far_q)); // R12
endmodule

// File: tb/sim_sysctl_regbank.sv
module sim_sysctl_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  acc_reg = '0;
   logic [3:0]  acc_crm = '0;
   logic [2:0]  acc_op2 = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_we = 1'b0;
   logic [31:0] acc_rdata;
   logic        stall;
   logic [9:0]  mem_req;
   logic        mem_done = 1'b0;
   logic        flt_capture = 1'b0;
   logic [3:0]  flt_status = '0;
   logic [3:0]  flt_domain = '0;
   logic [31:0] flt_addr = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sysctl_regbank u0 (
      .clk(clk), .rst_n(rst_n), .acc_reg(acc_reg), .acc_crm(acc_crm), .acc_op2(acc_op2),
      .acc_wdata(acc_wdata), .acc_we(acc_we), .acc_rdata(acc_rdata), .stall(stall),
      .mem_req(mem_req), .mem_done(mem_done), .flt_capture(flt_capture),
      .flt_status(flt_status), .flt_domain(flt_domain), .flt_addr(flt_addr)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] r, input logic [3:0] crm, input logic [2:0] op2, input logic [31:0] d);
      @(negedge clk);
      acc_reg = r; acc_crm = crm; acc_op2 = op2; acc_wdata = d; acc_we = 1'b1;
      @(negedge clk);
      acc_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] r, input logic [31:0] exp);
      acc_reg = r;
      #1;
      chk(req, acc_rdata, exp);
   endtask

   task automatic finish_cmd();
      @(negedge clk);
      mem_done = 1'b1;
      @(negedge clk);
      mem_done = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 ctrl", 4'd1, 32'h0000_4878);
      rd_chk("R1 id",   4'd0, 32'h5A01_0003);
      rd_chk("R1 ttb",  4'd2, 32'h0);
      rd_chk("R1 dom",  4'd3, 32'h0);
      rd_chk("R1 fsr",  4'd5, 32'h0);
      rd_chk("R1 far",  4'd6, 32'h0);
      rd_chk("R1 pid",  4'd13, 32'h0);
      chk("R1 stall", {31'b0, stall}, 32'h0);
      chk("R1 req", {22'b0, mem_req}, 32'h0);
   endtask

   task automatic t_ctrl();
      wr(4'd1, 4'd0, 3'd0, 32'hFFFF_FFFF);
      rd_chk("R2 ctrl all ones", 4'd1, 32'h0000_5B7D);
      wr(4'd1, 4'd0, 3'd0, 32'h0000_0000);
      rd_chk("R3 ctrl zeros keep forced", 4'd1, 32'h0000_4878);
      wr(4'd1, 4'd0, 3'd0, 32'h0000_1001);
      rd_chk("R2 ctrl partial", 4'd1, 32'h0000_5879);
      wr(4'd1, 4'd0, 3'd0, 32'hFFFF_A482);
      rd_chk("R3 ctrl fixed only", 4'd1, 32'h0000_4878);
   endtask

   task automatic t_ttb_dom();
      wr(4'd2, 4'd0, 3'd0, 32'hFFFF_FFFF);
      rd_chk("R4 ttb ones", 4'd2, 32'hFFFF_C000);
      wr(4'd2, 4'd0, 3'd0, 32'h1234_5678);
      rd_chk("R4 ttb pattern", 4'd2, 32'h1234_4000);
      wr(4'd3, 4'd0, 3'd0, 32'hA5C3_0F1E);
      rd_chk("R5 dom word", 4'd3, 32'hA5C3_0F1E);
      chk("R5 domain 15 field", {30'b0, acc_rdata[31:30]}, 32'h2);
      chk("R5 domain 0 field", {30'b0, acc_rdata[1:0]}, 32'h2);
   endtask

   task automatic t_fault_pid();
      wr(4'd5, 4'd0, 3'd0, 32'hFFFF_FFFF);
      rd_chk("R6 fsr write", 4'd5, 32'h0000_00FF);
      wr(4'd6, 4'd0, 3'd0, 32'hDEAD_BEEF);
      rd_chk("R6 far write", 4'd6, 32'hDEAD_BEEF);
      wr(4'd13, 4'd0, 3'd0, 32'hFFFF_FFFF);
      rd_chk("R7 pid ones", 4'd13, 32'hFE00_0000);
      wr(4'd13, 4'd0, 3'd0, 32'h5400_1234);
      rd_chk("R7 pid pattern", 4'd13, 32'h5400_0000);
      // capture collides with a software write to the status register
      @(negedge clk);
      acc_reg = 4'd5; acc_wdata = 32'h0000_0033; acc_we = 1'b1;
      flt_capture = 1'b1; flt_status = 4'hD; flt_domain = 4'h9; flt_addr = 32'h0BAD_F00D;
      @(negedge clk);
      acc_we = 1'b0; flt_capture = 1'b0;
      rd_chk("R11 fsr capture wins", 4'd5, 32'h0000_009D);
      rd_chk("R11 far capture", 4'd6, 32'h0BAD_F00D);
      @(negedge clk);
      acc_reg = 4'd6; acc_wdata = 32'h1111_2222; acc_we = 1'b1;
      flt_capture = 1'b1; flt_status = 4'h5; flt_domain = 4'h2; flt_addr = 32'hCAFE_0004;
      @(negedge clk);
      acc_we = 1'b0; flt_capture = 1'b0;
      rd_chk("R11 far capture wins", 4'd6, 32'hCAFE_0004);
      rd_chk("R11 fsr second", 4'd5, 32'h0000_0025);
   endtask

   task automatic t_maint(input string req, input logic [3:0] r, input logic [3:0] crm,
                          input logic [2:0] op2, input int bitpos);
      logic [31:0] exp;
      exp = 32'h1 << bitpos;
      wr(r, crm, op2, 32'h0);
      chk(req, {22'b0, mem_req}, exp);
      chk("R10 stall raised", {31'b0, stall}, 32'h1);
      @(negedge clk);
      @(negedge clk);
      chk("R10 request held", {22'b0, mem_req}, exp);
      finish_cmd();
      chk("R10 request released", {22'b0, mem_req}, 32'h0);
      chk("R10 stall dropped", {31'b0, stall}, 32'h0);
   endtask

   task automatic t_stall_block();
      wr(4'd3, 4'd0, 3'd0, 32'h1111_1111);
      wr(4'd7, 4'b0111, 3'd0, 32'h0);
      wr(4'd3, 4'd0, 3'd0, 32'h2222_2222);
      wr(4'd8, 4'b0101, 3'd0, 32'h0);
      chk("R12 req unchanged by write in stall", {22'b0, mem_req}, 32'h0000_0001);
      finish_cmd();
      rd_chk("R12 dom untouched in stall", 4'd3, 32'h1111_1111);
      chk("R12 stalled maint write dropped", {22'b0, mem_req}, 32'h0);
      // done while idle
      finish_cmd();
      chk("R12 idle done no effect", {22'b0, mem_req}, 32'h0);
      wr(4'd8, 4'b0110, 3'd0, 32'h0);
      chk("R12 next command accepted", {22'b0, mem_req}, 32'h0000_0200);
      finish_cmd();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_ttb_dom();
      t_fault_pid();
      t_maint("R8 flush all",      4'd7, 4'b0111, 3'd0, 0);
      t_maint("R8 flush I",        4'd7, 4'b0101, 3'd0, 1);
      t_maint("R8 flush D",        4'd7, 4'b0110, 3'd0, 2);
      t_maint("R8 clean all",      4'd7, 4'b1011, 3'd0, 3);
      t_maint("R8 clean D",        4'd7, 4'b1010, 3'd0, 4);
      t_maint("R8 clean flush all", 4'd7, 4'b1111, 3'd0, 5);
      t_maint("R8 clean flush D",  4'd7, 4'b1110, 3'd0, 6);
      t_maint("R8 default crm",    4'd7, 4'b0001, 3'd0, 5);
      t_maint("R8 default op2",    4'd7, 4'b0111, 3'd2, 5);
      t_maint("R9 tlb all",        4'd8, 4'b0111, 3'd0, 7);
      t_maint("R9 tlb I",          4'd8, 4'b0101, 3'd0, 8);
      t_maint("R9 tlb D",          4'd8, 4'b0110, 3'd0, 9);
      t_maint("R9 default crm",    4'd8, 4'b1010, 3'd0, 7);
      t_maint("R9 default op2",    4'd8, 4'b0110, 3'd1, 7);
      t_stall_block();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule